// File: doc/BRIEF.md
# Turn-Model Mesh Route Computation Unit

This unit sits at one input of a router in a two-dimensional mesh and decides where a packet goes next. For each head flit it compares the destination coordinates with the router's own coordinates and finds the productive directions, meaning the hops that shorten the remaining distance. It then removes the directions that the selected turn policy forbids and the directions whose links are flagged as failed. From what is left it picks one output port: east, west, north, south, or local ejection.

A static policy input selects one of four policies. Dimension-order XY routing has no choice. West-first, north-last and negative-first each forbid only some turns, so some packets keep a choice between two minimal directions. When a choice exists, the unit prefers a direction whose congestion flag is clear. If neither or both candidates are congested, it takes the X direction. If every permitted direction has failed, the unit reports that no route exists and selects no port.

The decision is registered. It is presented to the downstream allocator with a valid/ready handshake one cycle after the head flit is accepted.

Top module: `mesh_route_unit`

## Requirements
- R1: When the destination equals the local coordinates, the result is port code 0 (local) with no error. This holds whatever the flags are.
- R2: Routing is minimal. X grows to the east and Y grows to the north. A returned direction always reduces the distance: east only if dest_x > cur_x, west only if dest_x < cur_x, north only if dest_y > cur_y, south only if dest_y < cur_y.
- R3: Policy 0 (XY): while X distance remains, only the X direction is permitted. Otherwise only the Y direction is permitted.
- R4: Policy 1 (west-first): if west is productive, only west is permitted. Otherwise all productive directions among east, north and south are permitted.
- R5: Policy 2 (north-last): while any X distance remains, north is not permitted. The other productive directions are.
- R6: Policy 3 (negative-first): if west or south is productive, only west and south are permitted. Otherwise east and north are permitted.
- R7: Among usable permitted directions, one whose congestion bit is clear is preferred. If all are congested or all are clear, the X direction is taken before the Y direction.
- R8: A direction whose fail bit is set is never chosen. If no permitted direction is left, out_noroute is 1 and out_port is 7 (none). Flag bit order is 0 east, 1 west, 2 north, 3 south. Port codes are 1 east, 2 west, 3 north, 4 south.
- R9: in_ready equals (not out_valid) or out_ready. A flit accepted at a clock edge has its result on the outputs with out_valid high after that same edge.
- R10: While out_valid is high and out_ready is low, out_port and out_noroute stay unchanged.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy | input | 2 | Static turn policy: 0 XY, 1 west-first, 2 north-last, 3 negative-first |
| cur_x | input | COORD_W | Router's own X coordinate |
| cur_y | input | COORD_W | Router's own Y coordinate |
| in_valid | input | 1 | Head flit destination is present |
| in_ready | output | 1 | Unit can accept a head flit |
| dst_x | input | COORD_W | Destination X coordinate |
| dst_y | input | COORD_W | Destination Y coordinate |
| link_busy | input | 4 | Per-direction congestion flags |
| link_dead | input | 4 | Per-direction failure flags |
| out_valid | output | 1 | Route decision is present |
| out_ready | input | 1 | Allocator takes the decision |
| out_port | output | 3 | Chosen port code |
| out_noroute | output | 1 | No permitted direction remains |

## Verification
The hardest case to reach is the one where the flags decide the outcome. That needs a destination diagonal to the router under an adaptive policy, with the congestion and failure bits set so that the preferred direction is unusable or both candidates are tied. Directed vectors place the router at the middle of the mesh and aim at each of the four diagonal quadrants under every policy, walking the flag combinations. A long random phase then mixes destinations, flags and a randomly stalled out_ready, so that decisions are also held across back-pressure.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    localparam int NDIR = 4;
    localparam int DIR_E = 0;
    localparam int DIR_W = 1;
    localparam int DIR_N = 2;
    localparam int DIR_S = 3;

    typedef logic [NDIR-1:0] dirset_t;

    localparam dirset_t X_MASK   = dirset_t'((1 << DIR_E) | (1 << DIR_W));
    localparam dirset_t Y_MASK   = dirset_t'((1 << DIR_N) | (1 << DIR_S));
    localparam dirset_t NEG_MASK = dirset_t'((1 << DIR_W) | (1 << DIR_S));
    localparam dirset_t W_MASK   = dirset_t'(1 << DIR_W);
    localparam dirset_t N_MASK   = dirset_t'(1 << DIR_N);

    typedef enum logic [1:0] {
        POL_XY         = 2'd0,
        POL_WEST_FIRST = 2'd1,
        POL_NORTH_LAST = 2'd2,
        POL_NEG_FIRST  = 2'd3
    } policy_e;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4,
        PORT_NONE  = 3'd7
    } port_e;

    typedef struct packed {
        logic  valid;
        port_e port;
        logic  noroute;
    } route_reg_t;

endpackage

// File: rtl/mrc_productive.sv
module mrc_productive
    import mrc_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output dirset_t            prod,
    output logic               at_dest
);

    always_comb begin
        prod        = '0;
        prod[DIR_E] = dst_x > cur_x;
        prod[DIR_W] = dst_x < cur_x;
        prod[DIR_N] = dst_y > cur_y;
        prod[DIR_S] = dst_y < cur_y;
        at_dest     = (dst_x == cur_x) && (dst_y == cur_y);
    end

    // R2: an X hop and its opposite can never both be productive
    always_comb begin
        a_r2_no_opposite: assert (!(prod[DIR_E] && prod[DIR_W]) && !(prod[DIR_N] && prod[DIR_S]));
    end

endmodule

// File: rtl/mrc_turn_filter.sv
module mrc_turn_filter
    import mrc_pkg::*;
(
    input  policy_e pol,
    input  dirset_t prod,
    output dirset_t allowed
);

    dirset_t x_part;
    dirset_t neg_part;

    always_comb begin
        x_part   = prod & X_MASK;
        neg_part = prod & NEG_MASK;
        allowed  = prod;
        unique case (pol)
            POL_XY:         allowed = (x_part != '0) ? x_part : (prod & Y_MASK);
            POL_WEST_FIRST: allowed = prod[DIR_W] ? W_MASK : prod;
            POL_NORTH_LAST: allowed = (x_part != '0) ? (prod & ~N_MASK) : prod;
            POL_NEG_FIRST:  allowed = (neg_part != '0) ? neg_part : prod;
            default:        allowed = prod;
        endcase
    end

    always_comb begin
        // R2: the filter only removes directions
        a_r2_subset_of_prod: assert ((allowed & ~prod) == '0);
        // R3: dimension order leaves a single candidate
        a_r3_xy_single: assert (pol != POL_XY || $onehot0(allowed));
    end

endmodule

// File: rtl/mrc_select.sv
module mrc_select
    import mrc_pkg::*;
(
    input  dirset_t allowed,
    input  dirset_t busy,
    input  dirset_t dead,
    output port_e   port,
    output logic    noroute
);

    dirset_t usable;
    dirset_t calm;
    dirset_t pick;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign usable[d] = allowed[d] & ~dead[d];
        assign calm[d]   = usable[d] & ~busy[d];
    end

    always_comb begin
        pick    = (calm != '0) ? calm : usable;
        noroute = (usable == '0);
        if (pick[DIR_E])      port = PORT_EAST;
        else if (pick[DIR_W]) port = PORT_WEST;
        else if (pick[DIR_N]) port = PORT_NORTH;
        else if (pick[DIR_S]) port = PORT_SOUTH;
        else                  port = PORT_NONE;
    end

    always_comb begin
        // R8: a candidate always yields a port
        a_r8_pick_exists: assert (usable == '0 || port != PORT_NONE);
    end

endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mrc_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [3:0]         link_busy,
    input  logic [3:0]         link_dead,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [2:0]         out_port,
    output logic               out_noroute
);

    dirset_t    prod;
    dirset_t    allowed;
    logic       at_dest;
    port_e      sel_port;
    logic       sel_noroute;
    logic       accept;
    route_reg_t r_d, r_q;

    mrc_productive #(.COORD_W(COORD_W)) u_prod (
        .cur_x   (cur_x),
        .cur_y   (cur_y),
        .dst_x   (dst_x),
        .dst_y   (dst_y),
        .prod    (prod),
        .at_dest (at_dest)
    );

    mrc_turn_filter u_filter (
        .pol     (policy_e'(policy)),
        .prod    (prod),
        .allowed (allowed)
    );

    mrc_select u_sel (
        .allowed (allowed),
        .busy    (link_busy),
        .dead    (link_dead),
        .port    (sel_port),
        .noroute (sel_noroute)
    );

    assign in_ready = !r_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.valid   = 1'b1;
            r_d.port    = at_dest ? PORT_LOCAL : sel_port;
            r_d.noroute = at_dest ? 1'b0 : sel_noroute;
        end else if (out_ready) begin
            r_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.valid   <= 1'b0;
            r_q.port    <= PORT_NONE;
            r_q.noroute <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid   = r_q.valid;
    assign out_port    = r_q.port;
    assign out_noroute = r_q.noroute;

    a_r9_load_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_noroute)));

    a_r1_local: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dst_x == cur_x && dst_y == cur_y)
        |=> (out_port == PORT_LOCAL && !out_noroute));

    a_r2_no_x_when_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dst_x == cur_x)
        |=> (out_port != PORT_EAST && out_port != PORT_WEST));

    a_r8_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_noroute) |-> (out_port == PORT_NONE));

endmodule

// File: tb/tb_mesh_route_unit.sv
module tb_mesh_route_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] policy = '0;
    logic [3:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] link_busy = '0, link_dead = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [2:0] out_port;
    logic       out_noroute;

    int vectors = 0;
    int errors  = 0;

    // model state
    bit    m_valid = 0;
    int    m_port  = 7;
    bit    m_nr    = 0;
    string m_tag   = "R11";
    bit    m_held  = 0;

    always #2 clk = ~clk;

    mesh_route_unit #(.COORD_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .policy(policy),
        .cur_x(cur_x), .cur_y(cur_y),
        .in_valid(in_valid), .in_ready(in_ready),
        .dst_x(dst_x), .dst_y(dst_y),
        .link_busy(link_busy), .link_dead(link_dead),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_port(out_port), .out_noroute(out_noroute)
    );

    // behavioural reference: directions 0 E,1 W,2 N,3 S ; port = dir+1
    function automatic void ref_route(input int md, input int cx, input int cy,
                                      input int dx, input int dy,
                                      input bit [3:0] bz, input bit [3:0] dd,
                                      output int port, output bit nr);
        int ox = dx - cx;
        int oy = dy - cy;
        int cand[$];
        int live[$];
        port = 7;
        nr   = 0;
        if (ox == 0 && oy == 0) begin
            port = 0;
            return;
        end
        case (md)
            0: begin
                if (ox > 0) cand.push_back(0);
                else if (ox < 0) cand.push_back(1);
                else if (oy > 0) cand.push_back(2);
                else cand.push_back(3);
            end
            1: begin
                if (ox < 0) cand.push_back(1);
                else begin
                    if (ox > 0) cand.push_back(0);
                    if (oy > 0) cand.push_back(2);
                    if (oy < 0) cand.push_back(3);
                end
            end
            2: begin
                if (ox > 0) cand.push_back(0);
                if (ox < 0) cand.push_back(1);
                if (ox == 0 && oy > 0) cand.push_back(2);
                if (oy < 0) cand.push_back(3);
            end
            default: begin
                if (ox < 0 || oy < 0) begin
                    if (ox < 0) cand.push_back(1);
                    if (oy < 0) cand.push_back(3);
                end else begin
                    if (ox > 0) cand.push_back(0);
                    if (oy > 0) cand.push_back(2);
                end
            end
        endcase
        foreach (cand[i]) if (!dd[cand[i]]) live.push_back(cand[i]);
        if (live.size() == 0) begin
            nr = 1;
            return;
        end
        port = live[0] + 1;
        foreach (live[i]) begin
            if (!bz[live[i]]) begin
                port = live[i] + 1;
                break;
            end
        end
    endfunction

    task automatic compare();
        bit exp_rdy = !m_valid || out_ready;
        string t = m_held ? "R10" : m_tag;
        vectors++;
        if (in_ready !== exp_rdy) begin
            errors++;
            $display("FAIL R9 in_ready actual=%0b expected=%0b", in_ready, exp_rdy);
        end
        if (out_valid !== m_valid) begin
            errors++;
            $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, m_valid);
        end else if (m_valid) begin
            if (out_port !== 3'(m_port) || out_noroute !== m_nr) begin
                errors++;
                $display("FAIL %s port/noroute actual=%0d/%0b expected=%0d/%0b",
                         t, out_port, out_noroute, m_port, m_nr);
            end
        end
    endtask

    task automatic step(input int md, input int cx, input int cy, input int dx, input int dy,
                        input bit [3:0] bz, input bit [3:0] dd,
                        input bit iv, input bit ordy, input string tag);
        bit acc;
        int p;
        bit nr;
        @(negedge clk);
        compare();
        policy = 2'(md); cur_x = 4'(cx); cur_y = 4'(cy);
        dst_x = 4'(dx); dst_y = 4'(dy);
        link_busy = bz; link_dead = dd;
        in_valid = iv; out_ready = ordy;
        acc = iv && (!m_valid || ordy);
        @(posedge clk);
        if (acc) begin
            ref_route(md, cx, cy, dx, dy, bz, dd, p, nr);
            m_valid = 1; m_port = p; m_nr = nr; m_tag = tag; m_held = 0;
        end else if (ordy) begin
            m_valid = 0; m_held = 0;
        end else if (m_valid) begin
            m_held = 1;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R11: reset state
        repeat (3) begin
            @(negedge clk);
            vectors++;
            if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
                errors++;
                $display("FAIL R11 valid/ready actual=%0b/%0b expected=0/1", out_valid, in_ready);
            end
        end
        rst_n = 1'b1;

        // R1: local ejection even with all links dead and busy
        step(1, 5, 5, 5, 5, 4'hF, 4'hF, 1, 1, "R1");
        step(2, 0, 0, 0, 0, 4'h0, 4'hF, 1, 1, "R1");
        // R3: XY ignores congestion, X first, then Y
        step(0, 5, 5, 9, 9, 4'h1, 4'h0, 1, 1, "R3");
        step(0, 5, 5, 5, 2, 4'h0, 4'h0, 1, 1, "R3");
        step(0, 5, 5, 1, 9, 4'hF, 4'h0, 1, 1, "R3");
        step(0, 5, 5, 9, 9, 4'h0, 4'h1, 1, 1, "R8");
        // R4: west-first
        step(1, 5, 5, 1, 9, 4'h2, 4'h0, 1, 1, "R4");
        step(1, 5, 5, 1, 9, 4'h0, 4'h2, 1, 1, "R8");
        step(1, 5, 5, 9, 9, 4'h0, 4'h0, 1, 1, "R7");
        step(1, 5, 5, 9, 9, 4'h1, 4'h0, 1, 1, "R7");
        step(1, 5, 5, 9, 9, 4'h5, 4'h0, 1, 1, "R7");
        step(1, 5, 5, 9, 1, 4'h1, 4'h0, 1, 1, "R4");
        step(1, 5, 5, 9, 9, 4'h0, 4'h1, 1, 1, "R8");
        step(1, 5, 5, 9, 9, 4'h0, 4'h5, 1, 1, "R8");
        // R5: north-last
        step(2, 5, 5, 9, 9, 4'h1, 4'h0, 1, 1, "R5");
        step(2, 5, 5, 5, 9, 4'h4, 4'h0, 1, 1, "R5");
        step(2, 5, 5, 9, 1, 4'h1, 4'h0, 1, 1, "R5");
        step(2, 5, 5, 1, 9, 4'h0, 4'h2, 1, 1, "R8");
        // R6: negative-first
        step(3, 5, 5, 1, 9, 4'h2, 4'h0, 1, 1, "R6");
        step(3, 5, 5, 9, 1, 4'h8, 4'h0, 1, 1, "R6");
        step(3, 5, 5, 1, 1, 4'h2, 4'h0, 1, 1, "R6");
        step(3, 5, 5, 9, 9, 4'h1, 4'h0, 1, 1, "R6");
        step(3, 5, 5, 1, 1, 4'h0, 4'hA, 1, 1, "R8");
        // R9/R10: back-pressure; new flits offered while stalled are not taken
        step(1, 5, 5, 9, 9, 4'h1, 4'h0, 1, 0, "R9");
        step(0, 5, 5, 1, 1, 4'h0, 4'h0, 1, 0, "R10");
        step(3, 5, 5, 5, 5, 4'h0, 4'h0, 1, 0, "R10");
        step(0, 5, 5, 1, 1, 4'h0, 4'h0, 0, 1, "R9");
        step(0, 5, 5, 1, 1, 4'h0, 4'h0, 0, 0, "R9");

        // R2: random mix of everything
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(3), $urandom_range(15), $urandom_range(15),
                 $urandom_range(15), $urandom_range(15),
                 4'($urandom_range(15)), 4'($urandom_range(15) & $urandom_range(15)),
                 1'($urandom_range(3) != 0), 1'($urandom_range(3) != 0), "R2");
        end
        step(0, 0, 0, 0, 0, 4'h0, 4'h0, 0, 1, "R9");
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule